// File: doc/BRIEF.md
# Timer Trigger and DMA Request Router

This block is the routing layer that sits between a general-purpose timer's event logic and its neighbours. It picks which internal timer signal becomes the master trigger output used to synchronise slave timers. A 3-bit source code selects one of eight candidates: a software update strobe, the counter enable, the update event, a compare pulse, or one of four output-compare reference waveforms. Some of these sources come from the slave trigger input. For those, a one-cycle lag applies unless synchronisation mode is set.

The same block decides when each capture/compare channel raises its DMA request. Each request follows either its own channel event or the shared update event. The block also forms the channel-1 timer input. That input is either the channel-1 pin alone or the XOR of the first three channel pins, which gives a simple hall-sensor style input.

The counter, prescaler and compare units are outside this block. Their events and reference levels arrive as input strobes and levels. The control fields come in as plain inputs.

Top module: `tmr_route_top`

## Requirements
- R1: After reset, with every input held low, `trgo`, `dma_req` and `ti1` are all low, and every internal delay stage is cleared.
- R2: With `mst_mode` = 0, `trgo` is high in the cycle after `ug_wr` is high. It is also driven by the reset-mode trigger (`slv_mode_reset` AND `slv_trig`). That trigger appears one cycle late when `mst_sync` = 0 and in the same cycle when `mst_sync` = 1.
- R3: With `mst_mode` = 1, `trgo` equals the counter enable. The counter enable is `cen_bit` OR the gated trigger (`slv_mode_gated` AND `slv_trig`). The gated-trigger term lags one cycle when `mst_sync` = 0 and passes in the same cycle when `mst_sync` = 1. `cen_bit` never lags.
- R4: With `mst_mode` = 2, `trgo` equals `upd_evt` in the same cycle.
- R5: With `mst_mode` = 3, `trgo` is high for exactly the cycle after each cycle in which `cc_evt[0]` (the channel-1 flag-setting event) is high. This holds whatever the state of the flag. Events in consecutive cycles give a continuous high.
- R6: With `mst_mode` = 4, 5, 6 or 7, `trgo` equals `oc_ref[0]`, `oc_ref[1]`, `oc_ref[2]` or `oc_ref[3]` respectively, in the same cycle.
- R7: With `dma_on_upd` = 0, `dma_req[i]` equals `cc_evt[i]` for every channel i.
- R8: With `dma_on_upd` = 1, every bit of `dma_req` equals `upd_evt`, and `cc_evt` has no effect on `dma_req`.
- R9: With `ti1_xor_sel` = 0, `ti1` equals `ch_pin[0]`, and `ch_pin[1]` and `ch_pin[2]` have no effect. With `ti1_xor_sel` = 1, `ti1` equals `ch_pin[0]` XOR `ch_pin[1]` XOR `ch_pin[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_mode | input | 3 | Master trigger source code (0..7) |
| mst_sync | input | 1 | Synchronisation mode: bypass the trigger-path lag |
| dma_on_upd | input | 1 | 1: DMA requests on update event; 0: on channel event |
| ti1_xor_sel | input | 1 | 1: TI1 is XOR of three pins; 0: channel-1 pin |
| ug_wr | input | 1 | Software update-generate write strobe |
| cen_bit | input | 1 | Software counter enable bit |
| slv_mode_reset | input | 1 | Slave controller in reset mode |
| slv_mode_gated | input | 1 | Slave controller in gated mode |
| slv_trig | input | 1 | Slave trigger input |
| upd_evt | input | 1 | Update event strobe |
| cc_evt | input | NUM_CH | Capture/compare event strobes, bit 0 is channel 1 |
| oc_ref | input | NUM_CH | Output-compare reference levels, bit 0 is channel 1 |
| ch_pin | input | 3 | Channel pins 1..3 for TI1 forming |
| trgo | output | 1 | Master trigger output |
| dma_req | output | NUM_CH | Per-channel DMA requests |
| ti1 | output | 1 | Channel-1 timer input |

## Verification
The bench builds the block with its default of four channels. At that size every source code maps onto a real input and the whole channel vector can be compared as one value. It walks all eight source codes against both synchronisation settings. Each pairing gets a long run of random event patterns, so the lagged and bypassed trigger paths and back-to-back compare events all occur. Both DMA selections and all sixteen pin and select combinations for TI1 are then swept exhaustively.

// File: rtl/tmr_route_pkg.sv
package tmr_route_pkg;

  localparam int MODE_W  = 3;
  localparam int TI_PINS = 3;

  typedef enum logic [MODE_W-1:0] {
    MSRC_UG     = 3'd0,
    MSRC_CEN    = 3'd1,
    MSRC_UPD    = 3'd2,
    MSRC_CPULSE = 3'd3,
    MSRC_OC1    = 3'd4,
    MSRC_OC2    = 3'd5,
    MSRC_OC3    = 3'd6,
    MSRC_OC4    = 3'd7
  } msrc_e;

  // choose the same-cycle value when synchronisation bypasses the lag
  function automatic logic lag_or_pass(input logic sync, input logic now_v,
                                       input logic prev_v);
    return sync ? now_v : prev_v;
  endfunction

  // channel-1 input forming
  function automatic logic ti1_form(input logic sel,
                                    input logic [TI_PINS-1:0] p);
    return sel ? (^p) : p[0];
  endfunction

  // per-channel request selection
  function automatic logic dma_pick(input logic on_upd, input logic upd,
                                    input logic ch_evt);
    return on_upd ? upd : ch_evt;
  endfunction

endpackage

// File: rtl/tmr_trgo_sel.sv
module tmr_trgo_sel
  import tmr_route_pkg::*;
#(
  parameter int NUM_OC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              sync,
  input  logic              ug_wr,
  input  logic              rst_trig,
  input  logic              cen_bit,
  input  logic              gate_trig,
  input  logic              upd_evt,
  input  logic              cc1_evt,
  input  logic [NUM_OC-1:0] oc_ref,
  output logic              trgo
);

  localparam int NSRC    = 1 << MODE_W;
  localparam int OC_BASE = 4;
  localparam int OC_SLOT = NSRC - OC_BASE;

  // delay stages
  logic ug_q, rtrig_q, gtrig_q, cpulse_q, past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ug_q     <= 1'b0;
      rtrig_q  <= 1'b0;
      gtrig_q  <= 1'b0;
      cpulse_q <= 1'b0;
      past_ok  <= 1'b0;
    end else begin
      ug_q     <= ug_wr;
      rtrig_q  <= rst_trig;
      gtrig_q  <= gate_trig;
      cpulse_q <= cc1_evt;
      past_ok  <= 1'b1;
    end
  end

  // named source wires
  logic src_ug, src_cen, src_upd, src_cpulse;
  logic [NSRC-1:0] srcv;

  assign src_ug     = ug_q | lag_or_pass(sync, rst_trig, rtrig_q);
  assign src_cen    = cen_bit | lag_or_pass(sync, gate_trig, gtrig_q);
  assign src_upd    = upd_evt;
  assign src_cpulse = cpulse_q;

  assign srcv[MSRC_UG]     = src_ug;
  assign srcv[MSRC_CEN]    = src_cen;
  assign srcv[MSRC_UPD]    = src_upd;
  assign srcv[MSRC_CPULSE] = src_cpulse;

  for (genvar g = 0; g < OC_SLOT; g++) begin : g_oc
    if (g < NUM_OC) begin : g_has
      assign srcv[OC_BASE+g] = oc_ref[g];
    end else begin : g_none
      assign srcv[OC_BASE+g] = 1'b0;
    end
  end

  assign trgo = srcv[mode];

  // R2 update-generate appears one cycle after the write
  a_r2_ug_next: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode == MSRC_UG && $past(ug_wr)) |-> trgo);

  // R3 synchronised gated trigger passes in the same cycle
  a_r3_gate_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MSRC_CEN && sync) |-> (trgo == (cen_bit | gate_trig)));

  // R3 unsynchronised gated trigger lags one cycle
  a_r3_gate_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode == MSRC_CEN && !sync) |->
      (trgo == (cen_bit | $past(gate_trig))));

  // R4 update event passes directly
  a_r4_upd_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MSRC_UPD) |-> (trgo == upd_evt));

  // R5 compare pulse follows each channel-1 event by one cycle
  a_r5_cmp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode == MSRC_CPULSE) |-> (trgo == $past(cc1_evt)));

  // R6 reference waveform selection
  a_r6_oc_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MSRC_OC1) |-> (trgo == oc_ref[0]));

endmodule

// File: rtl/tmr_dma_route.sv
module tmr_dma_route
  import tmr_route_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_upd,
  input  logic              upd_evt,
  input  logic [NUM_CH-1:0] cc_evt,
  output logic [NUM_CH-1:0] dma_req
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign dma_req[c] = dma_pick(on_upd, upd_evt, cc_evt[c]);
  end

  // R7 channel-event routing
  a_r7_on_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !on_upd |-> (dma_req == cc_evt));

  // R8 update-event routing on every channel
  a_r8_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    on_upd |-> (dma_req == {NUM_CH{upd_evt}}));

endmodule

// File: rtl/tmr_ti1_comb.sv
module tmr_ti1_comb
  import tmr_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xor_sel,
  input  logic [TI_PINS-1:0] pin,
  output logic               ti1
);

  assign ti1 = ti1_form(xor_sel, pin);

  // R9 single-pin path
  a_r9_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !xor_sel |-> (ti1 == pin[0]));

  // R9 three-pin parity path
  a_r9_xor_pins: assert property (@(posedge clk) disable iff (!rst_n)
    xor_sel |-> (ti1 == ($countones(pin) % 2 == 1)));

endmodule

// File: rtl/tmr_route_top.sv
module tmr_route_top
  import tmr_route_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 mst_mode,
  input  logic                       mst_sync,
  input  logic                       dma_on_upd,
  input  logic                       ti1_xor_sel,
  input  logic                       ug_wr,
  input  logic                       cen_bit,
  input  logic                       slv_mode_reset,
  input  logic                       slv_mode_gated,
  input  logic                       slv_trig,
  input  logic                       upd_evt,
  input  logic [NUM_CH-1:0]          cc_evt,
  input  logic [NUM_CH-1:0]          oc_ref,
  input  logic [2:0]                 ch_pin,
  output logic                       trgo,
  output logic [NUM_CH-1:0]          dma_req,
  output logic                       ti1
);

  // slave-derived trigger events
  logic rst_trig, gate_trig;
  assign rst_trig  = slv_mode_reset & slv_trig;
  assign gate_trig = slv_mode_gated & slv_trig;

  tmr_trgo_sel #(.NUM_OC(NUM_CH)) u_trgo (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mst_mode),
    .sync      (mst_sync),
    .ug_wr     (ug_wr),
    .rst_trig  (rst_trig),
    .cen_bit   (cen_bit),
    .gate_trig (gate_trig),
    .upd_evt   (upd_evt),
    .cc1_evt   (cc_evt[0]),
    .oc_ref    (oc_ref),
    .trgo      (trgo)
  );

  tmr_dma_route #(.NUM_CH(NUM_CH)) u_dma (
    .clk     (clk),
    .rst_n   (rst_n),
    .on_upd  (dma_on_upd),
    .upd_evt (upd_evt),
    .cc_evt  (cc_evt),
    .dma_req (dma_req)
  );

  tmr_ti1_comb u_ti1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .xor_sel (ti1_xor_sel),
    .pin     (ch_pin),
    .ti1     (ti1)
  );

  // R1 outputs quiet right after reset with idle inputs
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !ug_wr && !slv_trig && !cen_bit && !upd_evt &&
     cc_evt == '0 && oc_ref == '0 && ch_pin == '0) |-> (!trgo && dma_req == '0 && !ti1));

endmodule

// File: tb/test_tmr_route_top.sv
`timescale 1ns/1ps
module test_tmr_route_top;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     mst_mode = '0;
  logic           mst_sync = 1'b0, dma_on_upd = 1'b0, ti1_xor_sel = 1'b0;
  logic           ug_wr = 1'b0, cen_bit = 1'b0;
  logic           slv_mode_reset = 1'b0, slv_mode_gated = 1'b0, slv_trig = 1'b0;
  logic           upd_evt = 1'b0;
  logic [NCH-1:0] cc_evt = '0, oc_ref = '0;
  logic [2:0]     ch_pin = '0;
  logic           trgo, ti1;
  logic [NCH-1:0] dma_req;

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side memory of the previous cycle's stimulus
  logic p_ug = 1'b0, p_rtrig = 1'b0, p_gtrig = 1'b0, p_cc1 = 1'b0;

  always #4 clk = ~clk;

  tmr_route_top #(.NUM_CH(NCH)) i_tmr_route_top (
    .clk(clk), .rst_n(rst_n), .mst_mode(mst_mode), .mst_sync(mst_sync),
    .dma_on_upd(dma_on_upd), .ti1_xor_sel(ti1_xor_sel), .ug_wr(ug_wr),
    .cen_bit(cen_bit), .slv_mode_reset(slv_mode_reset),
    .slv_mode_gated(slv_mode_gated), .slv_trig(slv_trig), .upd_evt(upd_evt),
    .cc_evt(cc_evt), .oc_ref(oc_ref), .ch_pin(ch_pin), .trgo(trgo),
    .dma_req(dma_req), .ti1(ti1)
  );

  task automatic check(input string req, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (mode %0d sync %0b)",
               req, act, exp, mst_mode, mst_sync);
    end
  endtask

  // expected trigger, restated from the requirements
  function automatic logic exp_trgo(output string tag);
    logic rt, gt;
    rt = slv_mode_reset & slv_trig;
    gt = slv_mode_gated & slv_trig;
    case (mst_mode)
      3'd0: begin tag = "R2"; exp_trgo = p_ug | (mst_sync ? rt : p_rtrig); end
      3'd1: begin tag = "R3"; exp_trgo = cen_bit | (mst_sync ? gt : p_gtrig); end
      3'd2: begin tag = "R4"; exp_trgo = upd_evt; end
      3'd3: begin tag = "R5"; exp_trgo = p_cc1; end
      default: begin tag = "R6"; exp_trgo = oc_ref[mst_mode - 3'd4]; end
    endcase
  endfunction

  task automatic remember();
    p_ug    = ug_wr;
    p_rtrig = slv_mode_reset & slv_trig;
    p_gtrig = slv_mode_gated & slv_trig;
    p_cc1   = cc_evt[0];
  endtask

  task automatic check_all();
    string tag;
    logic  e;
    logic  par;
    e = exp_trgo(tag);
    check(tag, {{(NCH-1){1'b0}}, trgo}, {{(NCH-1){1'b0}}, e});
    if (dma_on_upd) check("R8", dma_req, {NCH{upd_evt}});
    else            check("R7", dma_req, cc_evt);
    par = ch_pin[0] ^ ch_pin[1] ^ ch_pin[2];
    check("R9", {{(NCH-1){1'b0}}, ti1},
          {{(NCH-1){1'b0}}, (ti1_xor_sel ? par : ch_pin[0])});
  endtask

  // one cycle: drive at the falling edge, compare, note what the flops take
  task automatic step_rand();
    @(negedge clk);
    ug_wr          = 1'($urandom);
    cen_bit        = ($urandom % 4) == 0;
    slv_mode_reset = 1'($urandom);
    slv_mode_gated = 1'($urandom);
    slv_trig       = 1'($urandom);
    upd_evt        = 1'($urandom);
    cc_evt         = NCH'($urandom);
    oc_ref         = NCH'($urandom);
    ch_pin         = 3'($urandom);
    dma_on_upd     = 1'($urandom);
    ti1_xor_sel    = 1'($urandom);
    #1;
    check_all();
    remember();
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", {{(NCH-1){1'b0}}, trgo}, '0);
    check("R1", dma_req, '0);
    check("R1", {{(NCH-1){1'b0}}, ti1}, '0);
    @(negedge clk);
    #1;
    check("R1", {{(NCH-1){1'b0}}, trgo}, '0);

    // R5 directed: three consecutive events then silence
    @(negedge clk);
    mst_mode = 3'd3;
    for (int k = 0; k < 6; k++) begin
      cc_evt = (k < 3) ? 4'b0001 : 4'b0000;
      #1;
      check("R5", {{(NCH-1){1'b0}}, trgo},
            {{(NCH-1){1'b0}}, (k >= 1 && k <= 3)});
      remember();
      @(negedge clk);
    end

    // R2 directed: single write gives one high cycle later
    mst_mode = 3'd0;
    ug_wr = 1'b1;
    #1;
    check("R2", {{(NCH-1){1'b0}}, trgo}, '0);
    remember();
    @(negedge clk);
    ug_wr = 1'b0;
    #1;
    check("R2", {{(NCH-1){1'b0}}, trgo}, 4'b0001);
    remember();

    // sweep every source code against both sync settings
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        mst_mode = 3'(m);
        mst_sync = 1'(s);
        for (int n = 0; n < 150; n++) step_rand();
      end
    end

    // exhaustive TI1 and DMA selection sweeps (R7, R8, R9)
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      ti1_xor_sel = v[3];
      ch_pin      = v[2:0];
      for (int d = 0; d < 2; d++) begin
        dma_on_upd = 1'(d);
        cc_evt     = NCH'(v);
        upd_evt    = v[0];
        #1;
        check_all();
      end
      remember();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule